// File: doc/BRIEF.md
# Two-Core MESI Snoop Controller

This block keeps the private first-level caches of two processor cores coherent. Each core presents read and write requests carrying a byte address. The block compares addresses at 64-byte line granularity and keeps one MESI state per line per core. When a request needs the shared bus, the block issues a bus-read, a read-for-ownership or an upgrade transaction. It snoops the other core's copy in the same cycle and updates both cores' states together.

The requesting cache never chooses its own fill state. The controller looks at the other core first. A read miss then fills Exclusive when no other copy exists and Shared when one does. When a snoop hits a dirty line, the block raises a flush to the next level and counts a writeback against the core that supplied the line. Every snoop that invalidates a copy is counted against the core that lost it.

When both cores request in the same cycle, a round-robin arbiter accepts one of them and stalls the other through a valid/ready handshake. A query port shows both cores' states for any address, so the states can be observed. The data arrays, the tag lookup and the lower memory levels sit outside this block. The next level is treated as always ready.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: State codes are Invalid=0, Shared=1, Exclusive=2, Modified=3. After reset every line of both cores reads Invalid, and all four counters read zero.
- R2: A read to an Invalid line issues bus command 1 (bus-read) and asserts fill_valid. The fill state is Exclusive if the other core holds the line Invalid, and Shared otherwise.
- R3: When a core snoops the other core's read miss, Modified raises flush_valid and becomes Shared, Exclusive becomes Shared, and Shared stays Shared.
- R4: A write to a Shared line issues command 3 (upgrade) without fill_valid. A write to an Invalid line issues command 2 (read-for-ownership) with fill_valid and fill state Modified. A write to an Exclusive or Modified line issues no bus command.
- R5: Any command 2 or 3 moves the other core's copy to Invalid. If that copy was Modified, the block raises flush_valid with flush_core naming that core.
- R6: After any accepted write, the writing core's line reads Modified.
- R7: Each snoop flush adds one to the supplying core's writeback counter. Each snoop that moves a valid copy to Invalid adds one to that core's invalidation counter.
- R8: With both cores valid, exactly one is granted. The priority pointer starts at core 0 after reset and moves to the other core after each accepted request. ready is only ever high together with valid.
- R9: Two addresses that differ only in bits 5..0 address the same line, so they interact.
- R10: A read to a valid line issues no bus command and changes no state. bus, fill and flush outputs appear in the cycle after the request is accepted, and are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c0_valid | input | 1 | Core 0 request valid |
| c0_write | input | 1 | Core 0 request is a write |
| c0_addr | input | ADDR_W | Core 0 byte address |
| c0_ready | output | 1 | Core 0 request accepted this cycle |
| c1_valid | input | 1 | Core 1 request valid |
| c1_write | input | 1 | Core 1 request is a write |
| c1_addr | input | ADDR_W | Core 1 byte address |
| c1_ready | output | 1 | Core 1 request accepted this cycle |
| bus_valid | output | 1 | A bus transaction was issued |
| bus_cmd | output | 2 | 0 none, 1 bus-read, 2 read-for-ownership, 3 upgrade |
| bus_core | output | 1 | Core that issued the transaction |
| bus_line | output | ADDR_W-6 | Line index of the transaction |
| fill_valid | output | 1 | Requesting core fills the line from the next level |
| fill_state | output | 2 | State given to the filled line |
| flush_valid | output | 1 | Dirty line is written back to the next level |
| flush_core | output | 1 | Core that supplies the flushed line |
| q_addr | input | ADDR_W | Query address |
| q_st0 | output | 2 | Core 0 state of the queried line |
| q_st1 | output | 2 | Core 1 state of the queried line |
| wb_cnt0 | output | CNT_W | Core 0 snoop writeback count |
| wb_cnt1 | output | CNT_W | Core 1 snoop writeback count |
| inv_cnt0 | output | CNT_W | Core 0 snoop invalidation count |
| inv_cnt1 | output | CNT_W | Core 1 snoop invalidation count |

## Verification
Each wrong internal state shows up at the query port one cycle after the request that produced it. Examples are a fill given Exclusive while the other copy survives, or a Modified copy that is not cleared. Such a state also shows on the next transaction that touches the line. It could issue the wrong command, miss a flush, or leave two cores able to write. A counter that drifts is visible at once and never recovers. Ping-pong and false-sharing sequences therefore compare the states, flushes and counters after every single write.

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl #(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                c0_valid,
  input  logic                c0_write,
  input  logic [ADDR_W-1:0]   c0_addr,
  output logic                c0_ready,
  input  logic                c1_valid,
  input  logic                c1_write,
  input  logic [ADDR_W-1:0]   c1_addr,
  output logic                c1_ready,
  output logic                bus_valid,
  output logic [1:0]          bus_cmd,
  output logic                bus_core,
  output logic [ADDR_W-7:0]   bus_line,
  output logic                fill_valid,
  output logic [1:0]          fill_state,
  output logic                flush_valid,
  output logic                flush_core,
  input  logic [ADDR_W-1:0]   q_addr,
  output logic [1:0]          q_st0,
  output logic [1:0]          q_st1,
  output logic [CNT_W-1:0]    wb_cnt0,
  output logic [CNT_W-1:0]    wb_cnt1,
  output logic [CNT_W-1:0]    inv_cnt0,
  output logic [CNT_W-1:0]    inv_cnt1
);
  localparam int OFF    = 6;
  localparam int LW     = ADDR_W - OFF;
  localparam int NLINES = 1 << LW;

  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;
  localparam logic [1:0] CMD_NONE = 2'd0, CMD_RD = 2'd1, CMD_RDX = 2'd2, CMD_UPG = 2'd3;

  logic [1:0] st0 [NLINES];
  logic [1:0] st1 [NLINES];
  logic       prio;

  assign c0_ready = c0_valid & (~c1_valid | ~prio);
  assign c1_ready = c1_valid & (~c0_valid |  prio);

  wire          acc  = c0_ready | c1_ready;
  wire          rc   = c1_ready;
  wire          wr   = rc ? c1_write : c0_write;
  wire [LW-1:0] line = rc ? c1_addr[ADDR_W-1:OFF] : c0_addr[ADDR_W-1:OFF];
  wire [1:0]    sr   = rc ? st1[line] : st0[line];
  wire [1:0]    so   = rc ? st0[line] : st1[line];

  assign q_st0 = st0[q_addr[ADDR_W-1:OFF]];
  assign q_st1 = st1[q_addr[ADDR_W-1:OFF]];

  logic [1:0] nr, no, cmd;
  logic       fl, iv, fill;

  always_comb begin
    nr = sr; no = so; cmd = CMD_NONE; fl = 1'b0; iv = 1'b0; fill = 1'b0;
    if (wr) begin
      nr = ST_M;
      if (sr == ST_I) begin cmd = CMD_RDX; fill = 1'b1; end
      else if (sr == ST_S) cmd = CMD_UPG;
      if (cmd != CMD_NONE) begin
        no = ST_I;
        fl = (so == ST_M);
        iv = (so != ST_I);
      end
    end else if (sr == ST_I) begin
      cmd  = CMD_RD;
      fill = 1'b1;
      nr   = (so == ST_I) ? ST_E : ST_S;
      no   = (so == ST_I) ? ST_I : ST_S;
      fl   = (so == ST_M);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) begin
        st0[i] <= ST_I;
        st1[i] <= ST_I;
      end
      prio <= 1'b0;
      bus_valid <= 1'b0; bus_cmd <= CMD_NONE; bus_core <= 1'b0; bus_line <= '0;
      fill_valid <= 1'b0; fill_state <= ST_I;
      flush_valid <= 1'b0; flush_core <= 1'b0;
      wb_cnt0 <= '0; wb_cnt1 <= '0; inv_cnt0 <= '0; inv_cnt1 <= '0;
    end else begin
      bus_valid   <= acc && (cmd != CMD_NONE);
      bus_cmd     <= acc ? cmd : CMD_NONE;
      bus_core    <= rc;
      bus_line    <= line;
      fill_valid  <= acc & fill;
      fill_state  <= (acc & fill) ? nr : ST_I;
      flush_valid <= acc & fl;
      flush_core  <= ~rc;
      if (acc) begin
        prio <= ~rc;
        if (rc) begin
          st1[line] <= nr; st0[line] <= no;
          wb_cnt0  <= wb_cnt0  + CNT_W'(fl);
          inv_cnt0 <= inv_cnt0 + CNT_W'(iv);
        end else begin
          st0[line] <= nr; st1[line] <= no;
          wb_cnt1  <= wb_cnt1  + CNT_W'(fl);
          inv_cnt1 <= inv_cnt1 + CNT_W'(iv);
        end
      end
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({c1_ready, c0_ready})); // R8
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_ready -> c0_valid) && (c1_ready -> c1_valid)); // R8
  AST_RR_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_valid && c1_valid && c0_ready) ##1 (c0_valid && c1_valid) |-> c1_ready); // R8
  AST_SINGLE_OWNER0: assert property (@(posedge clk) disable iff (!rst_n)
    (q_st0 == ST_M || q_st0 == ST_E) |-> q_st1 == ST_I); // R5
  AST_SINGLE_OWNER1: assert property (@(posedge clk) disable iff (!rst_n)
    (q_st1 == ST_M || q_st1 == ST_E) |-> q_st0 == ST_I); // R5
  AST_FLUSH_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> bus_valid && bus_core != flush_core); // R3
  AST_NO_FILL_ON_UPG: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> bus_valid && bus_cmd != CMD_UPG); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(c0_valid || c1_valid) |=> !bus_valid && !fill_valid && !flush_valid); // R10
  AST_WB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_valid |-> $stable(wb_cnt0) && $stable(wb_cnt1)); // R7
endmodule

// File: tb/tb_mesi_snoop_ctrl.sv
`timescale 1ns/1ps
module tb_mesi_snoop_ctrl;
  localparam int AW = 12;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic c0_valid = 0, c0_write = 0, c1_valid = 0, c1_write = 0;
  logic [AW-1:0] c0_addr = '0, c1_addr = '0, q_addr = '0;
  logic c0_ready, c1_ready, bus_valid, bus_core, fill_valid, flush_valid, flush_core;
  logic [1:0] bus_cmd, fill_state, q_st0, q_st1;
  logic [AW-7:0] bus_line;
  logic [CW-1:0] wb_cnt0, wb_cnt1, inv_cnt0, inv_cnt1;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mesi_snoop_ctrl #(.ADDR_W(AW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n),
    .c0_valid(c0_valid), .c0_write(c0_write), .c0_addr(c0_addr), .c0_ready(c0_ready),
    .c1_valid(c1_valid), .c1_write(c1_write), .c1_addr(c1_addr), .c1_ready(c1_ready),
    .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_core(bus_core), .bus_line(bus_line),
    .fill_valid(fill_valid), .fill_state(fill_state),
    .flush_valid(flush_valid), .flush_core(flush_core),
    .q_addr(q_addr), .q_st0(q_st0), .q_st1(q_st1),
    .wb_cnt0(wb_cnt0), .wb_cnt1(wb_cnt1), .inv_cnt0(inv_cnt0), .inv_cnt1(inv_cnt1));

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // vector: core, write, addr, cmd, req state, other state, flush
  localparam int NV = 12;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 1'b0, 12'h040, 2'd1, 2'd2, 2'd0, 1'b0},
    {1'b0, 1'b0, 12'h048, 2'd0, 2'd2, 2'd0, 1'b0},
    {1'b1, 1'b0, 12'h044, 2'd1, 2'd1, 2'd1, 1'b0},
    {1'b1, 1'b1, 12'h040, 2'd3, 2'd3, 2'd0, 1'b0},
    {1'b0, 1'b0, 12'h07C, 2'd1, 2'd1, 2'd1, 1'b1},
    {1'b0, 1'b1, 12'h040, 2'd3, 2'd3, 2'd0, 1'b0},
    {1'b0, 1'b1, 12'h040, 2'd0, 2'd3, 2'd0, 1'b0},
    {1'b1, 1'b1, 12'h050, 2'd2, 2'd3, 2'd0, 1'b1},
    {1'b0, 1'b1, 12'h080, 2'd2, 2'd3, 2'd0, 1'b0},
    {1'b1, 1'b0, 12'h0C0, 2'd1, 2'd2, 2'd0, 1'b0},
    {1'b1, 1'b1, 12'h0C0, 2'd0, 2'd3, 2'd0, 1'b0},
    {1'b0, 1'b0, 12'h0C0, 2'd1, 2'd1, 2'd1, 1'b1}
  };

  task automatic issue(input bit core, input bit wr, input logic [AW-1:0] a);
    @(negedge clk);
    if (core) begin c1_valid = 1; c1_write = wr; c1_addr = a; end
    else      begin c0_valid = 1; c0_write = wr; c0_addr = a; end
    q_addr = a;
    #1 chk("R8 sole ready", core ? c1_ready : c0_ready, 1);
    @(negedge clk);
    c0_valid = 0; c1_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    q_addr = 12'h040;
    chk("R1 reset st0", q_st0, 0);
    chk("R1 reset st1", q_st1, 0);
    chk("R1 reset cnt", wb_cnt0 + wb_cnt1 + inv_cnt0 + inv_cnt1, 0);
    chk("R10 reset bus", bus_valid, 0);

    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      v = VEC[i];
      issue(v[20], v[19], v[18:7]);
      chk("R2 R4 R10 cmd", bus_cmd, v[6:5]);
      chk("R10 bus_valid", bus_valid, int'(v[6:5] != 0));
      chk("R3 R6 req state", v[20] ? q_st1 : q_st0, v[4:3]);
      chk("R3 R5 other state", v[20] ? q_st0 : q_st1, v[2:1]);
      chk("R3 R5 flush", flush_valid, v[0]);
      if (v[0]) chk("R5 flush_core", flush_core, int'(!v[20]));
      if (v[6:5] == 2'd1 || v[6:5] == 2'd2) chk("R2 fill state", fill_state, v[4:3]);
      else chk("R4 no fill", fill_valid, 0);
      if (v[6:5] != 0) chk("R9 line", bus_line, v[18:13]);
    end
    chk("R7 wb0", wb_cnt0, 1);
    chk("R7 wb1", wb_cnt1, 2);
    chk("R7 inv0", inv_cnt0, 2);
    chk("R7 inv1", inv_cnt1, 1);

    // ping-pong on line 5, false sharing between offsets
    for (int k = 0; k < 8; k++) begin
      bit c;
      c = k[0];
      issue(c, 1'b1, c ? 12'h144 : 12'h140);
      chk("R4 ping-pong cmd", bus_cmd, 2);
      chk("R5 ping-pong flush", flush_valid, int'(k != 0));
      chk("R6 ping-pong writer M", c ? q_st1 : q_st0, 3);
      chk("R5 ping-pong other I", c ? q_st0 : q_st1, 0);
    end
    chk("R7 pp inv0", inv_cnt0, 2 + 4);
    chk("R7 pp inv1", inv_cnt1, 1 + 3);
    chk("R7 pp wb0", wb_cnt0, 1 + 4);
    chk("R7 pp wb1", wb_cnt1, 2 + 3);

    // contention: prio should be core 0 (last accepted was core 1)
    @(negedge clk);
    c0_valid = 1; c0_write = 0; c0_addr = 12'h1C0;
    c1_valid = 1; c1_write = 0; c1_addr = 12'h1C8;
    #1 chk("R8 c0 wins", c0_ready, 1);
    chk("R8 c1 stalled", c1_ready, 0);
    @(negedge clk);
    c0_valid = 0;
    q_addr = 12'h1C0;
    chk("R2 first reader E", q_st0, 2);
    #1 chk("R8 c1 now ready", c1_ready, 1);
    @(negedge clk);
    c1_valid = 0;
    chk("R2 second reader S", q_st1, 1);
    chk("R3 E to S", q_st0, 1);
    @(negedge clk);
    c0_valid = 1; c0_write = 1; c0_addr = 12'h200;
    c1_valid = 1; c1_write = 1; c1_addr = 12'h240;
    #1 chk("R8 rr back to c0", c0_ready, 1);
    @(negedge clk);
    #1 chk("R8 then c1", c1_ready, 1);
    @(negedge clk);
    c0_valid = 0; c1_valid = 0;
    q_addr = 12'h240;
    chk("R6 c1 write M", q_st1, 3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule